// File: doc/BRIEF.md
# UART register and interrupt front end

This block is the software-visible face of one on-chip serial channel. A simple word-aligned bus reaches eight registers: line format, error status, interrupt enables, interrupt flags, FIFO reset control, baud setting, and the transmit and receive data ports. The shift engine, the FIFO storage and the baud counter sit outside. They connect through a push strobe, a pop strobe, full/available flags, an error pulse and static configuration outputs.

Interrupt flags are sticky. The hardware sets them, and software clears a flag by writing the flag register back with that bit at zero. A single interrupt line is raised while any enabled flag is pending. FIFO resets are driven by holding bits of the FIFO control register, so writing 7 and then 0 gives a reset pulse on both FIFOs.

Top module: `uart_regif`

## Requirements
- R1: After reset every register reads 0, and irq_o, the format outputs, the baud outputs and both FIFO reset outputs are low. This holds while tx_full_i is high and rx_avail_i and rx_err_i are low.
- R2: The byte offsets are 0x00 control, 0x04 error status, 0x08 interrupt enable, 0x0C interrupt flags, 0x10 FIFO control, 0x14 baud, 0x20 transmit data and 0x30 receive data. The control register keeps only mask 0x003D. Any other address, a misaligned one included, ignores writes and reads 0.
- R3: Control bit 0 drives cfg_char7_o (1 = 7-bit characters, 0 = 8-bit). Bit 2 drives cfg_stop2_o. Bit 4 drives cfg_par_en_o and bit 3 drives cfg_par_even_o, so 0x18 is even parity and 0x10 is odd parity. Bit 5 drives cfg_brg_clk_o.
- R4: The baud register keeps mask 0x03FF. Bits 7:0 drive baud_div_o and bits 9:8 drive baud_sel_o.
- R5: The interrupt-enable register keeps mask 0x0003, where bit 0 is receive and bit 1 is transmit. irq_o is high when the receive enable is set and flag bit 0 or flag bit 2 is set, or when the transmit enable is set and flag bit 1 is set.
- R6: In the flag register, bit 0 is set on any cycle with rx_avail_i high. Bit 1 is set on any cycle with tx_full_i low and no push. Bit 2 is set by an rx_err_i pulse, and that pulse also sets error-status bit 0.
- R7: Writing the flag register clears each flag whose written bit is 0 and leaves alone each flag whose written bit is 1. A set condition in the same cycle as a clear wins.
- R8: Writing the error-status register with bit 0 at 0 clears the error status; the flag register is left unchanged.
- R9: The FIFO control register keeps mask 0x0007. fifo_rst_rx_o is bit 0 AND bit 1, and fifo_rst_tx_o is bit 0 AND bit 2.
- R10: A write to the transmit data port pulses tx_push_o with the low byte on tx_data_o in the same cycle, but only when tx_full_i is low. Flag bit 1 is 0 on the cycle after a push.
- R11: A read of the receive data port returns rx_data_i in bits 7:0. It pulses rx_pop_o in the same cycle only when rx_avail_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus access valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational |
| tx_push_o | output | 1 | Push byte into transmit FIFO |
| tx_data_o | output | 8 | Byte to push |
| tx_full_i | input | 1 | Transmit FIFO full |
| rx_pop_o | output | 1 | Pop byte from receive FIFO |
| rx_data_i | input | 8 | Head of receive FIFO |
| rx_avail_i | input | 1 | Receive FIFO not empty |
| rx_err_i | input | 1 | Receive error pulse |
| cfg_char7_o | output | 1 | 7-bit character select |
| cfg_stop2_o | output | 1 | Two stop bits |
| cfg_par_en_o | output | 1 | Parity enable |
| cfg_par_even_o | output | 1 | Even parity select |
| cfg_brg_clk_o | output | 1 | Transfer clock from baud generator |
| baud_div_o | output | 8 | Baud divisor |
| baud_sel_o | output | 2 | Baud prescaler select |
| fifo_rst_rx_o | output | 1 | Receive FIFO reset |
| fifo_rst_tx_o | output | 1 | Transmit FIFO reset |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: an 8-bit address and a 16-bit data word. The 8-bit address covers every register offset as well as unmapped and misaligned addresses. The 16-bit word is wide enough that all-ones writes exercise every reserved bit above each register's mask, including the baud prescaler field. These widths also reach the races that matter, such as a flag clear that lands in the same cycle as its set condition and a push that lands on a full FIFO.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam int NREG    = 8;
  localparam int IDX_CR  = 0;
  localparam int IDX_SR  = 1;
  localparam int IDX_ICR = 2;
  localparam int IDX_ISR = 3;
  localparam int IDX_FCR = 4;
  localparam int IDX_BRG = 5;
  localparam int IDX_TXB = 6;
  localparam int IDX_RXB = 7;

  localparam logic [15:0] CR_MASK  = 16'h003D;
  localparam logic [15:0] ICR_MASK = 16'h0003;
  localparam logic [15:0] FCR_MASK = 16'h0007;
  localparam logic [15:0] BRG_MASK = 16'h03FF;

  function automatic logic [7:0] reg_off(input int idx);
    case (idx)
      IDX_CR:  return 8'h00;
      IDX_SR:  return 8'h04;
      IDX_ICR: return 8'h08;
      IDX_ISR: return 8'h0C;
      IDX_FCR: return 8'h10;
      IDX_BRG: return 8'h14;
      IDX_TXB: return 8'h20;
      default: return 8'h30;
    endcase
  endfunction
endpackage

// File: rtl/uart_regif_dec.sv
module uart_regif_dec
  import uart_regif_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NREG-1:0]   hit_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign hit_o[i] = (addr_i == ADDR_W'(reg_off(i)));
  end
endmodule

// File: rtl/uart_regif_reg.sv
module uart_regif_reg #(
  parameter int              DATA_W = 16,
  parameter logic [DATA_W-1:0] MASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i & MASK;
  end
endmodule

// File: rtl/uart_regif_flags.sv
module uart_regif_flags (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       isr_we_i,
  input  logic [2:0] isr_wbits_i,
  input  logic       sr_we_i,
  input  logic       sr_wbit_i,
  input  logic       rx_avail_i,
  input  logic       tx_full_i,
  input  logic       tx_push_i,
  input  logic       rx_err_i,
  output logic [2:0] isr_q_o,
  output logic       sr_err_q_o
);
  logic [2:0] keep, isr_d;
  logic       sr_d;

  always_comb begin
    keep     = isr_we_i ? isr_wbits_i : 3'b111;
    // set conditions override a software clear
    isr_d[0] = (isr_q_o[0] & keep[0]) | rx_avail_i;
    isr_d[1] = ((isr_q_o[1] & keep[1]) | ~tx_full_i) & ~tx_push_i;
    isr_d[2] = (isr_q_o[2] & keep[2]) | rx_err_i;
    sr_d     = (sr_err_q_o & (~sr_we_i | sr_wbit_i)) | rx_err_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q_o    <= '0;
      sr_err_q_o <= 1'b0;
    end else begin
      isr_q_o    <= isr_d;
      sr_err_q_o <= sr_d;
    end
  end
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              tx_push_o,
  output logic [7:0]        tx_data_o,
  input  logic              tx_full_i,
  output logic              rx_pop_o,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_avail_i,
  input  logic              rx_err_i,
  output logic              cfg_char7_o,
  output logic              cfg_stop2_o,
  output logic              cfg_par_en_o,
  output logic              cfg_par_even_o,
  output logic              cfg_brg_clk_o,
  output logic [7:0]        baud_div_o,
  output logic [1:0]        baud_sel_o,
  output logic              fifo_rst_rx_o,
  output logic              fifo_rst_tx_o,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] CR_M  = DATA_W'(CR_MASK);
  localparam logic [DATA_W-1:0] ICR_M = DATA_W'(ICR_MASK);
  localparam logic [DATA_W-1:0] FCR_M = DATA_W'(FCR_MASK);
  localparam logic [DATA_W-1:0] BRG_M = DATA_W'(BRG_MASK);

  logic [NREG-1:0]   hit;
  logic              wr, rd;
  logic              cr_we, icr_we, fcr_we, brg_we, isr_we, sr_we;
  logic [DATA_W-1:0] cr_q, icr_q, fcr_q, brg_q;
  logic [2:0]        isr_q;
  logic              sr_err_q;

  uart_regif_dec #(.ADDR_W(ADDR_W)) u_dec (.addr_i(addr_i), .hit_o(hit));

  assign wr     = sel_i & we_i;
  assign rd     = sel_i & ~we_i;
  assign cr_we  = wr & hit[IDX_CR];
  assign icr_we = wr & hit[IDX_ICR];
  assign fcr_we = wr & hit[IDX_FCR];
  assign brg_we = wr & hit[IDX_BRG];
  assign isr_we = wr & hit[IDX_ISR];
  assign sr_we  = wr & hit[IDX_SR];

  uart_regif_reg #(.DATA_W(DATA_W), .MASK(CR_M)) u_cr (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cr_we), .d_i(wdata_i), .q_o(cr_q));
  uart_regif_reg #(.DATA_W(DATA_W), .MASK(ICR_M)) u_icr (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(icr_we), .d_i(wdata_i), .q_o(icr_q));
  uart_regif_reg #(.DATA_W(DATA_W), .MASK(FCR_M)) u_fcr (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(fcr_we), .d_i(wdata_i), .q_o(fcr_q));
  uart_regif_reg #(.DATA_W(DATA_W), .MASK(BRG_M)) u_brg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(brg_we), .d_i(wdata_i), .q_o(brg_q));

  assign tx_push_o = wr & hit[IDX_TXB] & ~tx_full_i;
  assign tx_data_o = wdata_i[7:0];
  assign rx_pop_o  = rd & hit[IDX_RXB] & rx_avail_i;

  uart_regif_flags u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .isr_we_i(isr_we), .isr_wbits_i(wdata_i[2:0]),
    .sr_we_i(sr_we), .sr_wbit_i(wdata_i[0]),
    .rx_avail_i(rx_avail_i), .tx_full_i(tx_full_i), .tx_push_i(tx_push_o),
    .rx_err_i(rx_err_i),
    .isr_q_o(isr_q), .sr_err_q_o(sr_err_q));

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      if (hit[IDX_CR])       rdata_o = cr_q;
      else if (hit[IDX_SR])  rdata_o = DATA_W'(sr_err_q);
      else if (hit[IDX_ICR]) rdata_o = icr_q;
      else if (hit[IDX_ISR]) rdata_o = DATA_W'(isr_q);
      else if (hit[IDX_FCR]) rdata_o = fcr_q;
      else if (hit[IDX_BRG]) rdata_o = brg_q;
      else if (hit[IDX_RXB]) rdata_o = DATA_W'(rx_data_i);
    end
  end

  assign cfg_char7_o    = cr_q[0];
  assign cfg_stop2_o    = cr_q[2];
  assign cfg_par_even_o = cr_q[3];
  assign cfg_par_en_o   = cr_q[4];
  assign cfg_brg_clk_o  = cr_q[5];
  assign baud_div_o     = brg_q[7:0];
  assign baud_sel_o     = brg_q[9:8];
  assign fifo_rst_rx_o  = fcr_q[0] & fcr_q[1];
  assign fifo_rst_tx_o  = fcr_q[0] & fcr_q[2];

  // error flag shares the receive enable
  assign irq_o = (icr_q[0] & (isr_q[0] | isr_q[2])) | (icr_q[1] & isr_q[1]);
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] wdata_i,
  input logic              cr_we,
  input logic              isr_we,
  input logic [DATA_W-1:0] cr_q,
  input logic [DATA_W-1:0] icr_q,
  input logic [DATA_W-1:0] fcr_q,
  input logic [2:0]        isr_q,
  input logic              sr_err_q,
  input logic              tx_push_o,
  input logic              tx_full_i,
  input logic              rx_pop_o,
  input logic              rx_avail_i,
  input logic              rx_err_i,
  input logic              fifo_rst_rx_o,
  input logic              fifo_rst_tx_o,
  input logic              irq_o
);
  localparam logic [DATA_W-1:0] CR_M = DATA_W'(16'h003D);

  p_cr_store_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_we |=> cr_q == ($past(wdata_i) & CR_M));
  p_irq_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (icr_q[1:0] == 2'b00) |-> !irq_o);
  p_err_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_err_i |=> (isr_q[2] && sr_err_q));
  p_isr_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isr_we && wdata_i[0] && isr_q[0]) |=> isr_q[0]);
  p_fifo_arm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_rst_rx_o || fifo_rst_tx_o) |-> fcr_q[0]);
  p_push_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push_o |-> !tx_full_i);
  p_push_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push_o |=> !isr_q[1]);
  p_pop_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |-> rx_avail_i);
endmodule

bind uart_regif uart_regif_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wdata_i(wdata_i),
  .cr_we(cr_we), .isr_we(isr_we),
  .cr_q(cr_q), .icr_q(icr_q), .fcr_q(fcr_q), .isr_q(isr_q), .sr_err_q(sr_err_q),
  .tx_push_o(tx_push_o), .tx_full_i(tx_full_i),
  .rx_pop_o(rx_pop_o), .rx_avail_i(rx_avail_i), .rx_err_i(rx_err_i),
  .fifo_rst_rx_o(fifo_rst_rx_o), .fifo_rst_tx_o(fifo_rst_tx_o), .irq_o(irq_o));

// File: tb/tb_uart_regif.sv
`timescale 1ns/1ps
module tb_uart_regif;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int NVEC   = 11;
  // {addr, write data, expected readback}
  localparam logic [39:0] VEC [NVEC] = '{
    {8'h00, 16'h003F, 16'h003D},
    {8'h00, 16'hFFFF, 16'h003D},
    {8'h00, 16'h0018, 16'h0018},
    {8'h08, 16'hFFFF, 16'h0003},
    {8'h08, 16'h0002, 16'h0002},
    {8'h14, 16'hFFFF, 16'h03FF},
    {8'h14, 16'h0105, 16'h0105},
    {8'h10, 16'h00FF, 16'h0007},
    {8'h10, 16'h0000, 16'h0000},
    {8'h18, 16'hFFFF, 16'h0000},
    {8'h02, 16'hFFFF, 16'h0000}
  };

  logic clk = 0, rst_ni = 0;
  logic sel = 0, we = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0, rdata;
  logic tx_push, rx_pop, tx_full = 1, rx_avail = 0, rx_err = 0;
  logic [7:0] tx_data, rx_data = '0, baud_div;
  logic [1:0] baud_sel;
  logic c7, s2, pen, peven, bclk, frx, ftx, irq;
  int n_tests = 0, n_fail = 0;
  logic [DATA_W-1:0] rv;
  logic last_push, last_pop;
  logic [7:0] last_txd;

  always #2.5 clk = ~clk;

  uart_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_push_o(tx_push), .tx_data_o(tx_data),
    .tx_full_i(tx_full), .rx_pop_o(rx_pop), .rx_data_i(rx_data),
    .rx_avail_i(rx_avail), .rx_err_i(rx_err), .cfg_char7_o(c7), .cfg_stop2_o(s2),
    .cfg_par_en_o(pen), .cfg_par_even_o(peven), .cfg_brg_clk_o(bclk),
    .baud_div_o(baud_div), .baud_sel_o(baud_sel), .fifo_rst_rx_o(frx),
    .fifo_rst_tx_o(ftx), .irq_o(irq));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    sel = 1; we = 1; addr = a; wdata = d;
    #1 last_push = tx_push; last_txd = tx_data;
    @(posedge clk);
    #1 sel = 0; we = 0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk);
    sel = 1; we = 0; addr = a;
    #1 rv = rdata; last_pop = rx_pop;
    @(posedge clk);
    #1 sel = 0;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  initial begin
    #(20000 * 5);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    // R1 reset state
    foreach (VEC[i]) begin
      rd(VEC[i][39:32]);
      chk("R1 reset readback", rv, 0);
    end
    rd(8'h04); chk("R1 reset SR", rv, 0);
    rd(8'h0C); chk("R1 reset ISR", rv, 0);
    chk("R1 reset outputs", {irq, c7, s2, pen, peven, bclk, frx, ftx, baud_div, baud_sel}, 0);

    // R2 R4 R5 R9 masked storage and address map
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][39:32], VEC[i][31:16]);
      rd(VEC[i][39:32]);
      chk("R2 map/mask", rv, VEC[i][15:0]);
    end

    // R3 line format
    wr(8'h00, 16'h0018); settle();
    chk("R3 even parity", {pen, peven, c7, s2, bclk}, 5'b11000);
    wr(8'h00, 16'h0010); settle();
    chk("R3 odd parity", {pen, peven, c7, s2, bclk}, 5'b10000);
    wr(8'h00, 16'h0025); settle();
    chk("R3 7bit 2stop brg", {pen, peven, c7, s2, bclk}, 5'b00111);
    wr(8'h00, 16'h0000);

    // R4 baud fields
    wr(8'h14, 16'h0305); settle();
    chk("R4 baud fields", {baud_sel, baud_div}, 10'h305);

    // R9 FIFO reset pulse
    wr(8'h10, 16'h0007); settle();
    chk("R9 both resets", {frx, ftx}, 2'b11);
    wr(8'h10, 16'h0000); settle();
    chk("R9 resets released", {frx, ftx}, 2'b00);
    wr(8'h10, 16'h0006); settle();
    chk("R9 unarmed", {frx, ftx}, 2'b00);
    wr(8'h10, 16'h0003); settle();
    chk("R9 rx only", {frx, ftx}, 2'b10);
    wr(8'h10, 16'h0000);

    // R6 R5 receive flag and gating
    wr(8'h08, 16'h0000);
    @(negedge clk) rx_avail = 1;
    @(negedge clk) rx_avail = 0;
    rd(8'h0C); chk("R6 rx flag set", rv, 1);
    chk("R5 irq masked", irq, 0);
    wr(8'h08, 16'h0001); settle();
    chk("R5 irq rx", irq, 1);
    // R7 write 1 keeps, write 0 clears
    wr(8'h0C, 16'h0001);
    rd(8'h0C); chk("R7 write one keeps", rv, 1);
    wr(8'h0C, 16'h0006);
    rd(8'h0C); chk("R7 write zero clears", rv, 0);
    chk("R5 irq drops", irq, 0);
    // R7 set wins over clear
    @(negedge clk) rx_avail = 1;
    wr(8'h0C, 16'h0000);
    rd(8'h0C); chk("R7 set wins", rv, 1);
    @(negedge clk) rx_avail = 0;
    wr(8'h0C, 16'h0000);
    rd(8'h0C); chk("R7 cleared", rv, 0);

    // R6 R8 error
    @(negedge clk) rx_err = 1;
    @(negedge clk) rx_err = 0;
    rd(8'h0C); chk("R6 err flag", rv, 4);
    rd(8'h04); chk("R6 err status", rv, 1);
    chk("R5 irq on error", irq, 1);
    wr(8'h04, 16'h0000);
    rd(8'h04); chk("R8 status cleared", rv, 0);
    rd(8'h0C); chk("R8 flag kept", rv, 4);
    wr(8'h0C, 16'h0000);

    // R10 transmit
    wr(8'h08, 16'h0002);
    @(negedge clk) tx_full = 0;
    rd(8'h0C); chk("R6 tx flag set", rv, 2);
    chk("R5 irq tx", irq, 1);
    wr(8'h20, 16'h12A5);
    chk("R10 push pulse", {last_push, last_txd}, 9'h1A5);
    rd(8'h0C); chk("R10 tx flag drop", rv, 0);
    rd(8'h0C); chk("R10 tx flag back", rv, 2);
    @(negedge clk) tx_full = 1;
    wr(8'h20, 16'h005A);
    chk("R10 push blocked", last_push, 0);
    wr(8'h0C, 16'h0000);
    wr(8'h08, 16'h0000);

    // R11 receive data
    @(negedge clk) begin rx_avail = 1; rx_data = 8'h3C; end
    rd(8'h30);
    chk("R11 rx data", rv, 16'h003C);
    chk("R11 pop", last_pop, 1);
    @(negedge clk) rx_avail = 0;
    rd(8'h30);
    chk("R11 no pop empty", last_pop, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule